// File: doc/BRIEF.md
# SPI Shift-Register Target with Shared-Line and Cascade Support

This block is the target (peripheral) end of a four-wire synchronous serial link. It runs entirely on the local system clock. The serial clock, the active-low select and the incoming data line each pass through a two-flop synchroniser. Edges of the serial clock are then detected locally, so the system clock must run at least four times faster than the serial clock. During a selected transfer the block captures one bit from the controller on every sample edge, most significant bit first. On every shift edge it presents the next bit of its outgoing word on the return line.

The outgoing word comes from the `tx_word` input and is loaded when the select line falls. In clock-phase-0 modes the first bit is therefore already on the line before the first serial clock edge. While the block is not selected, its return line is released to high impedance, so several targets can share that line. In cascade mode no word is loaded. The return line then carries the bits received on the input line one full word earlier, including bits received in an earlier transfer. Several targets can then be chained on one select line.

When the select line rises after a whole number of words, the last word received appears on `rx_word` together with a one-cycle `rx_valid` strobe. A trailing partial word produces no strobe.

Top module: `spi_tgt`

## Requirements
- R1: While reset is asserted, `rx_valid` is 0, `rx_word` is 0 and `miso_oe` is 0.
- R2: `miso_oe` is 1 once `csn_i` has been low for three system clock cycles, and 0 once `csn_i` has been high for three. While `miso_oe` is 0, `miso_o` is high impedance.
- R3: With `cfg_chain`=0, `tx_word` is captured at the falling edge of the select. It is sent MSB first, and each bit is valid at the controller's sample edge. With `cfg_cpha`=0 the MSB is already on `miso_o` before the first serial clock edge.
- R4: `cfg_cpol` is the idle level of the serial clock. The leading edge is the transition away from that level. With `cfg_cpha`=0, MOSI is sampled on the leading edge and MISO changes on the trailing edge. With `cfg_cpha`=1 the two edges swap roles, and the first leading edge leaves the MSB in place. Received data is MSB first.
- R5: When the select rises after N sampled bits, where N is a nonzero multiple of WORD_W, `rx_valid` pulses for exactly one cycle. `rx_word` then holds the last WORD_W bits sampled. This also holds when the final serial clock edge and the select rising edge reach the block in the same cycle.
- R6: If N is zero or not a multiple of WORD_W, no strobe is given and `rx_word` keeps its value.
- R7: With `cfg_chain`=1, `tx_word` is ignored. `miso_o` emits each MOSI bit exactly WORD_W bit times after it was received, and the delay runs on across select boundaries.
- R8: Serial clock edges and MOSI activity while the select is high change nothing: no bit is shifted or counted.
- R9: `rx_word` changes only in the cycle in which `rx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_chain | input | 1 | 1: cascade pass-through, no response load |
| tx_word | input | WORD_W | Response word loaded at select fall |
| rx_word | output | WORD_W | Last complete word received |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| sclk_i | input | 1 | Serial clock from the controller |
| csn_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller, high impedance when deselected |
| miso_oe | output | 1 | Drive enable of `miso_o` |

## Verification
The select rising edge and the last serial clock edge can be detected in the same system cycle. In phase-1 modes this is a sample edge, so the final bit has to be merged into the word while the strobe is raised. In phase-0 modes it is the final shift. The bench provokes this in all four modes by changing the serial clock and the select at the same instant. The strobed word must still hold every bit, the strobe must come exactly once, and the cascade contents must match a model that delays MOSI by one word.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Events decoded from the synchronised serial clock and select.
  typedef struct packed {
    logic sel;      // previous select sample was active
    logic cs_fall;  // select just became active
    logic cs_rise;  // select just became inactive
    logic samp;     // capture edge for MOSI
    logic shft;     // launch edge for MISO
  } spi_evt_t;

  // Leading edge: a change of level that moves away from the idle level.
  function automatic logic is_lead(input logic cur, input logic prev,
                                   input logic idle);
    return (cur != prev) && (cur != idle);
  endfunction

  function automatic logic is_trail(input logic cur, input logic prev,
                                    input logic idle);
    return (cur != prev) && (cur == idle);
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
  import spi_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     csn_s,
  input  logic     cpol,
  input  logic     cpha,
  output spi_evt_t evt
);

  logic sclk_q, csn_q;
  logic lead, trail;

  // previous-sample registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  always_comb begin
    lead        = is_lead(sclk_s, sclk_q, cpol);
    trail       = is_trail(sclk_s, sclk_q, cpol);
    evt.sel     = ~csn_q;
    evt.cs_fall = csn_q & ~csn_s;
    evt.cs_rise = ~csn_q & csn_s;
    // edges count while the previous select sample was active, so an
    // edge that arrives together with the select rise is still taken
    evt.samp    = ~csn_q & (cpha ? trail : lead);
    evt.shft    = ~csn_q & (cpha ? lead  : trail);
  end

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_evt_t          evt,
  input  logic              mosi_s,
  input  logic              chain,
  input  logic [WORD_W-1:0] tx_word,
  output logic              miso_bit,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr,   sr_n;
  logic              smp,  smp_n;
  logic              pend, pend_n;
  logic [CNT_W-1:0]  cnt,  cnt_n;
  logic              full, full_n;
  logic              strobe;
  logic              bit_in, have;

  // next-state logic
  always_comb begin
    sr_n   = sr;
    smp_n  = smp;
    pend_n = pend;
    cnt_n  = cnt;
    full_n = full;
    strobe = 1'b0;
    bit_in = evt.samp ? mosi_s : smp;
    have   = evt.samp | pend;

    if (evt.cs_fall) begin
      if (!chain) sr_n = tx_word;
      pend_n = 1'b0;
      cnt_n  = '0;
      full_n = 1'b0;
    end else if (evt.sel) begin
      if (evt.samp) begin
        smp_n  = mosi_s;
        pend_n = 1'b1;
        if (cnt == LAST) begin
          cnt_n  = '0;
          full_n = 1'b1;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      // a sampled bit enters the register on the next shift edge, or at
      // once when the select closes the transfer
      if ((evt.shft && pend) || (evt.cs_rise && have)) begin
        sr_n   = {sr[WORD_W-2:0], bit_in};
        pend_n = 1'b0;
      end
      if (evt.cs_rise) strobe = full_n && (cnt_n == '0);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      smp      <= 1'b0;
      pend     <= 1'b0;
      cnt      <= '0;
      full     <= 1'b0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      sr       <= sr_n;
      smp      <= smp_n;
      pend     <= pend_n;
      cnt      <= cnt_n;
      full     <= full_n;
      rx_valid <= strobe;
      if (strobe) rx_word <= sr_n;
    end
  end

  assign miso_bit = sr[WORD_W-1];

endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_chain,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe
);

  logic [2:0] pins_s;
  logic       sclk_s, csn_s, mosi_s;
  logic       miso_bit;
  spi_evt_t   evt;

  // bit order {sclk, csn, mosi}; select resets inactive
  spi_tgt_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_i, csn_i, mosi_i}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign csn_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_tgt_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (sclk_s),
    .csn_s  (csn_s),
    .cpol   (cfg_cpol),
    .cpha   (cfg_cpha),
    .evt    (evt)
  );

  spi_tgt_shift #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .mosi_s   (mosi_s),
    .chain    (cfg_chain),
    .tx_word  (tx_word),
    .miso_bit (miso_bit),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

  assign miso_oe = ~csn_s;
  assign miso_o  = miso_oe ? miso_bit : 1'bz;

endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_i,
  input logic              sclk_i,
  input logic              miso_o,
  input logic              miso_oe,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_word
);

  // R2: select held high for three samples releases the line
  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && $past(csn_i) && $past(csn_i, 2)) |-> !miso_oe);

  // R2: select held low for three samples drives the line
  p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_i && !$past(csn_i) && !$past(csn_i, 2)) |-> miso_oe);

  // R5: the strobe lasts one cycle
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: the strobe comes only after deselection
  p_strobe_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !miso_oe);

  // R9: the received word holds between strobes
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));

  // R3: with a quiet serial clock the driven bit does not move
  p_miso_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && $past(miso_oe, 2) &&
     $stable(sclk_i) &&
     ($past(sclk_i, 1) == $past(sclk_i, 2)) &&
     ($past(sclk_i, 2) == $past(sclk_i, 3)) &&
     ($past(sclk_i, 3) == $past(sclk_i, 4)) &&
     ($past(sclk_i, 4) == $past(sclk_i, 5)))
    |-> $stable(miso_o));

endmodule

bind spi_tgt spi_tgt_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn_i    (csn_i),
  .sclk_i   (sclk_i),
  .miso_o   (miso_o),
  .miso_oe  (miso_oe),
  .rx_valid (rx_valid),
  .rx_word  (rx_word)
);

// File: tb/spi_tgt_bench.sv
`timescale 1ns/1ps
module spi_tgt_bench;

  localparam int W  = 8;
  localparam int HP = 6;  // serial half period in system cycles

  logic         clk, rst_n;
  logic         cpol, cpha, chain;
  logic [W-1:0] txw;
  logic [W-1:0] rx_word;
  logic         rx_valid;
  logic         sclk, csn, mosi;
  wire          miso;
  logic         miso_oe;

  int           checks = 0;
  int           fails  = 0;
  int           pulses = 0;
  bit           done   = 0;
  logic [W-1:0] cap;
  logic [W-1:0] m_sr;   // bench view of the target's shift contents
  logic [W-1:0] m_rx;   // bench view of the last strobed word
  int unsigned  seed;

  spi_tgt #(.WORD_W(W)) u_spi_tgt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_cpol  (cpol),
    .cfg_cpha  (cpha),
    .cfg_chain (chain),
    .tx_word   (txw),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid),
    .sclk_i    (sclk),
    .csn_i     (csn),
    .mosi_i    (mosi),
    .miso_o    (miso),
    .miso_oe   (miso_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      pulses++;
      cap = rx_word;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // One transfer of nb bits from d (MSB first) in the current mode.
  task automatic xfer(input int nb, input logic [63:0] d,
                      input bit same_end, input string tag);
    logic [63:0]  got, expm;
    logic [W-1:0] ex_sr;
    int           p0;
    bit           last;
    p0    = pulses;
    got   = '0;
    expm  = '0;
    ex_sr = chain ? m_sr : txw;
    sclk  = cpol;
    wclk(2);
    csn  = 1'b0;
    mosi = (nb > 0) ? d[nb-1] : 1'b0;
    wclk(HP);
    chk(miso_oe === 1'b1, "R2 enable while selected", 64'(miso_oe), 64'd1);
    for (int i = nb - 1; i >= 0; i--) begin
      last  = (i == 0);
      expm  = {expm[62:0], ex_sr[W-1]};
      ex_sr = {ex_sr[W-2:0], d[i]};
      if (!cpha) begin
        sclk = ~cpol;
        got  = {got[62:0], miso};
        wclk(HP);
        sclk = cpol;
        if (!last) mosi = d[i-1];
        if (last && same_end) csn = 1'b1;
        wclk(HP);
      end else begin
        sclk = ~cpol;
        mosi = d[i];
        wclk(HP);
        sclk = cpol;
        got  = {got[62:0], miso};
        if (last && same_end) csn = 1'b1;
        wclk(HP);
      end
    end
    csn = 1'b1;
    wclk(8);
    m_sr = ex_sr;
    if (nb > 0) chk(got == expm, {tag, " miso stream"}, got, expm);
    if (nb > 0 && (nb % W) == 0) begin
      m_rx = ex_sr;
      chk(pulses == p0 + 1, "R5 single strobe", 64'(pulses - p0), 64'd1);
      chk(cap == m_rx, "R5 strobed word", 64'(cap), 64'(m_rx));
    end else begin
      chk(pulses == p0, "R6 no strobe", 64'(pulses - p0), 64'd0);
    end
    chk(rx_word == m_rx, "R9 word held", 64'(rx_word), 64'(m_rx));
    chk(miso_oe === 1'b0, "R2 released when deselected", 64'(miso_oe), 64'd0);
  endtask

  task automatic set_mode(input int m);
    cpol = m[1];
    cpha = m[0];
    sclk = cpol;
    wclk(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    seed  = $urandom(32'd4242);
    rst_n = 1'b0;
    cpol  = 1'b0;
    cpha  = 1'b0;
    chain = 1'b0;
    txw   = '0;
    sclk  = 1'b0;
    csn   = 1'b1;
    mosi  = 1'b0;
    m_sr  = '0;
    m_rx  = '0;
    wclk(5);
    // R1
    chk(rx_valid == 1'b0, "R1 reset strobe", 64'(rx_valid), 64'd0);
    chk(rx_word == '0, "R1 reset word", 64'(rx_word), 64'd0);
    chk(miso_oe == 1'b0, "R1 reset enable", 64'(miso_oe), 64'd0);
    rst_n = 1'b1;
    wclk(4);

    // R3 directed, mode 0
    set_mode(0);
    txw = 8'h3C;
    xfer(8, 64'hA5, 0, "R3");
    txw = 8'h81;
    xfer(8, 64'h7E, 0, "R3");

    // R4 every mode with random data
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int k = 0; k < 3; k++) begin
        txw = W'($urandom);
        xfer(8, 64'($urandom), 0, "R4");
      end
    end

    // R5 last edge and select rise arriving together
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      txw = W'($urandom);
      xfer(8, 64'($urandom), 1, "R5 same-cycle");
    end

    // R5 two words under one select
    set_mode(0);
    txw = 8'hF0;
    xfer(16, 64'hC3_5A, 0, "R5 multiword");
    set_mode(3);
    txw = W'($urandom);
    xfer(16, 64'($urandom), 1, "R5 multiword");

    // R6 partial and empty transfers
    set_mode(1);
    txw = 8'h99;
    xfer(12, 64'hABC, 0, "R6 partial");
    set_mode(2);
    xfer(0, 64'h0, 0, "R6 empty");
    xfer(3, 64'h5, 1, "R6 partial");

    // R7 cascade: tx_word ignored, one-word delay across selects
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      chain = 1'b1;
      txw = W'($urandom);
      xfer(8, 64'($urandom), 0, "R7");
      txw = W'($urandom);
      xfer(24, 64'($urandom), m[0], "R7");
    end

    // R8 activity while deselected leaves the contents alone
    set_mode(0);
    xfer(8, 64'h96, 0, "R7");
    for (int t = 0; t < 10; t++) begin
      sclk = ~sclk;
      mosi = 1'($urandom);
      wclk(HP);
    end
    sclk = cpol;
    wclk(4);
    chk(pulses >= 0 && rx_word == m_rx, "R8 word untouched", 64'(rx_word), 64'(m_rx));
    xfer(8, 64'h0F, 0, "R8");

    chain = 1'b0;
    set_mode(0);
    txw = 8'h5A;
    xfer(8, 64'h24, 0, "R3");

    finish_run();
  end

endmodule